// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Divider

This block divides one 32-bit binary floating-point operand by another (1 sign bit, 8-bit exponent biased by 127, 23-bit fraction, with subnormal, infinite and NaN encodings). A request is launched with a one-cycle `start_i` pulse while the unit is idle. The unit sorts out special operands first. It then forms the quotient exponent as dividend exponent minus divisor exponent plus the bias, and rejects exponents that are certain to overflow or underflow before any division work. The 24-bit significands are divided by a restoring loop that yields one quotient bit per clock. The quotient is then normalized and rounded to nearest, ties to even.

The result and the three flags (overflow, underflow, divide by zero) are registered. They change only in the cycle that `done_o` pulses, and they hold until the next request completes. Subnormal operands are normalized on entry. A result whose biased exponent would be zero or less is flushed to a signed zero with the underflow flag. A result whose biased exponent would reach 255 becomes a signed infinity with the overflow flag.

The controller has five states. IDLE goes to PREP when `start_i` is high. PREP goes to DIV when the operands need a real division, and to FIN for a special or early-rejected case. DIV goes to ROUND after the last quotient bit. ROUND goes to FIN. FIN goes to IDLE.

Top module: `fpdiv_seq`

## Requirements
- R1: After reset `busy_o` and `done_o` are low, and `quot_o`, `ovf_o`, `unf_o` and `dbz_o` are all zero.
- R2: A NaN on either operand, zero divided by zero, and infinity divided by infinity all give the quiet NaN 0x7FC00000 with all three flags low.
- R3: A zero dividend with a non-NaN, nonzero divisor gives a zero whose sign is the XOR of the operand signs (bit 31). This holds for an infinite divisor too. No flag is raised, and `done_o` pulses 2 cycles after the `start_i` edge.
- R4: A zero divisor gives an infinity (exponent field 0xFF, fraction 0) signed by the XOR of the operand signs. `dbz_o` is set only when the dividend is finite and nonzero; an infinite dividend over zero raises no flag.
- R5: An infinite dividend over a finite nonzero divisor gives a signed infinity. A finite nonzero dividend over an infinite divisor gives a signed zero. Neither raises a flag.
- R6: For finite nonzero operands the quotient exponent starts as Ea - Eb + 127. A subnormal operand first has its significand shifted left until its leading one is at bit 23, and its effective exponent is 1 minus that shift.
- R7: If Ea - Eb + 127 is 256 or more, the result is a signed infinity with `ovf_o`. If it is 0 or less, the result is a signed zero with `unf_o`. Both are reported 2 cycles after the `start_i` edge, without a division.
- R8: An ordinary division completes with `done_o` 29 cycles after the `start_i` edge. `busy_o` is high from the cycle after that edge through the `done_o` cycle. A `start_i` pulse while busy is ignored.
- R9: When the significand ratio is below 1.0, the quotient is shifted left one place and the exponent is decremented by one.
- R10: The quotient is rounded to nearest even from its 24 kept bits, a guard bit, and a sticky bit. The sticky bit ORs every later quotient bit and a nonzero final remainder.
- R11: After rounding, a biased exponent of 255 or more gives a signed infinity with `ovf_o`. A biased exponent of 0 or less gives a signed zero with `unf_o`. At most one flag is ever set.
- R12: `done_o` is a one-cycle pulse. `quot_o` and the flags hold their values while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch a division; accepted only while idle |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: result and flags are fresh |
| quot_o | output | 32 | Quotient |
| ovf_o | output | 1 | Exponent overflow |
| unf_o | output | 1 | Exponent underflow (result flushed to zero) |
| dbz_o | output | 1 | Finite nonzero dividend divided by zero |

## Verification
The bench goes after the order of the special cases. 0/0 must come out as NaN, not as zero or infinity. Infinity over zero must give infinity with the divide-by-zero flag left low. A design that tests the zero divisor before the zero dividend, or that flags every zero divisor, fails these checks.

Subnormal operands are divided against normal ones. A design that skips normalization returns a wrong exponent or significand, or misses an overflow that only the effective exponent reveals. Quotients whose significand ratio is below one check the left shift and exponent decrement. Quotients that round up and round down check the guard and sticky bits.

Exponents just inside the early-reject window (255 and 1) are driven through the full division and must overflow or underflow late, after 29 cycles. Exponents just outside it must be rejected after 2 cycles. A `start_i` pulse with new operands during a division must not disturb the result or cause a second completion.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    // Controller states
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PREP  = 3'd1,
        S_DIV   = 3'd2,
        S_ROUND = 3'd3,
        S_FIN   = 3'd4
    } fsm_state_t;

    // Outcome of operand screening in PREP
    typedef enum logic [2:0] {
        K_DIV  = 3'd0,   // ordinary division needed
        K_NAN  = 3'd1,   // quiet NaN
        K_ZERO = 3'd2,   // signed zero, no flag
        K_INF  = 3'd3,   // signed infinity, no flag
        K_DBZ  = 3'd4,   // signed infinity, divide-by-zero flag
        K_OVF  = 3'd5,   // early exponent overflow
        K_UNF  = 3'd6    // early exponent underflow
    } op_kind_t;

endpackage

// File: rtl/fpdiv_unpack.sv
// Splits one operand into class bits, an effective exponent and a
// significand whose leading one sits at bit FRAC_W (subnormals normalized).
module fpdiv_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]    op_i,
    output logic                     sign_o,
    output logic                     zero_o,
    output logic                     inf_o,
    output logic                     nan_o,
    output logic signed [EXP_W+2:0]  exp_o,
    output logic [FRAC_W:0]          sig_o
);
    localparam int W   = 1 + EXP_W + FRAC_W;
    localparam int XW  = EXP_W + 3;
    localparam int SW  = FRAC_W + 1;
    localparam int LZW = $clog2(FRAC_W + 1);

    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] ffield;
    logic              e_all0;
    logic              e_all1;
    logic [LZW-1:0]    lz;
    logic              seen_one;

    assign efield = op_i[FRAC_W +: EXP_W];
    assign ffield = op_i[FRAC_W-1:0];
    assign e_all0 = ~|efield;
    assign e_all1 = &efield;

    assign sign_o = op_i[W-1];
    assign zero_o = e_all0 & ~|ffield;
    assign inf_o  = e_all1 & ~|ffield;
    assign nan_o  = e_all1 & |ffield;

    // leading-zero count of the fraction field
    always_comb begin
        lz       = '0;
        seen_one = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!seen_one) begin
                if (ffield[i]) begin
                    seen_one = 1'b1;
                end else begin
                    lz = lz + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (e_all0) begin
            sig_o = SW'(ffield) << (lz + 1'b1);
            exp_o = -$signed({{(XW - LZW){1'b0}}, lz});
        end else begin
            sig_o = {1'b1, ffield};
            exp_o = $signed({{(XW - EXP_W){1'b0}}, efield});
        end
    end

endmodule

// File: rtl/fpdiv_restore.sv
// Restoring significand divider: one quotient bit per step.
module fpdiv_restore #(
    parameter int SW = 24,
    parameter int QW = SW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [SW-1:0] divd_i,
    input  logic [SW-1:0] dvsr_i,
    output logic [QW-1:0] quot_o,
    output logic          rem_nz_o
);
    localparam int RW = SW + 2;

    logic [RW-1:0] rem_q;
    logic [SW-1:0] dvsr_q;
    logic [QW-1:0] quot_q;
    logic [RW-1:0] trial;
    logic          fits;
    logic [RW-1:0] kept;

    assign fits  = rem_q >= RW'(dvsr_q);
    assign trial = rem_q - RW'(dvsr_q);
    assign kept  = fits ? trial : rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            dvsr_q <= '0;
            quot_q <= '0;
        end else if (load_i) begin
            rem_q  <= RW'(divd_i);
            dvsr_q <= dvsr_i;
            quot_q <= '0;
        end else if (step_i) begin
            quot_q <= {quot_q[QW-2:0], fits};
            rem_q  <= kept << 1;
        end
    end

    assign quot_o   = quot_q;
    assign rem_nz_o = |rem_q;

endmodule

// File: rtl/fpdiv_round.sv
// Normalizes the raw quotient, rounds to nearest even and packs the result.
module fpdiv_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W+2:0]        quot_i,
    input  logic                     rem_nz_i,
    input  logic signed [EXP_W+2:0]  exp_i,
    input  logic                     sign_i,
    output logic [EXP_W+FRAC_W:0]    res_o,
    output logic                     ovf_o,
    output logic                     unf_o
);
    localparam int QW   = FRAC_W + 3;
    localparam int XW   = EXP_W + 3;
    localparam int EMAX = (1 << EXP_W) - 1;

    logic [FRAC_W-1:0]     frac_raw;
    logic                  lsb;
    logic                  guard;
    logic                  sticky;
    logic signed [XW-1:0]  exp_n;
    logic signed [XW-1:0]  exp_r;
    logic                  up;
    logic [FRAC_W:0]       frac_sum;

    // normalization: integer bit set, or shift left one place (R9)
    always_comb begin
        if (quot_i[QW-1]) begin
            frac_raw = quot_i[QW-2:2];
            guard    = quot_i[1];
            sticky   = quot_i[0] | rem_nz_i;
            exp_n    = exp_i;
        end else begin
            frac_raw = quot_i[QW-3:1];
            guard    = quot_i[0];
            sticky   = rem_nz_i;
            exp_n    = exp_i - XW'(1);
        end
    end

    // round to nearest even (R10)
    assign lsb      = frac_raw[0];
    assign up       = guard & (sticky | lsb);
    assign frac_sum = {1'b0, frac_raw} + (FRAC_W + 1)'(up);
    assign exp_r    = exp_n + XW'(frac_sum[FRAC_W]);

    // late range check and packing (R11)
    always_comb begin
        ovf_o = int'(exp_r) >= EMAX;
        unf_o = int'(exp_r) <= 0;
        if (ovf_o) begin
            res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (unf_o) begin
            res_o = {sign_i, {(EXP_W + FRAC_W){1'b0}}};
        end else begin
            res_o = {sign_i, exp_r[EXP_W-1:0], frac_sum[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/fpdiv_seq.sv
module fpdiv_seq
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [EXP_W+FRAC_W:0]   dividend_i,
    input  logic [EXP_W+FRAC_W:0]   divisor_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [EXP_W+FRAC_W:0]   quot_o,
    output logic                    ovf_o,
    output logic                    unf_o,
    output logic                    dbz_o
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int XW    = EXP_W + 3;
    localparam int SW    = FRAC_W + 1;
    localparam int QW    = SW + 2;
    localparam int CW    = $clog2(QW);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int EOVF  = 1 << EXP_W;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W - 1){1'b0}}};

    fsm_state_t state_q, state_d;
    op_kind_t   kind;

    logic [W-1:0]          opa_q, opb_q;
    logic [CW-1:0]         cnt_q;
    logic signed [XW-1:0]  exp_q;
    logic signed [XW-1:0]  exp_pre;
    logic                  res_sign;
    logic [W-1:0]          spec_res;
    logic                  load, step, last_bit;

    logic                  sa, za, ia, na;
    logic                  sb, zb, ib, nb;
    logic signed [XW-1:0]  ea, eb;
    logic [SW-1:0]         ma, mb;

    logic [QW-1:0]         raw_q;
    logic                  rem_nz;
    logic [W-1:0]          rnd_res;
    logic                  rnd_ovf, rnd_unf;

    logic [W-1:0]          res_q;
    logic                  ovf_q, unf_q, dbz_q;

    // ---------------- operand front end ----------------
    fpdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_unp_a (
        .op_i(opa_q), .sign_o(sa), .zero_o(za), .inf_o(ia), .nan_o(na),
        .exp_o(ea), .sig_o(ma)
    );

    fpdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_unp_b (
        .op_i(opb_q), .sign_o(sb), .zero_o(zb), .inf_o(ib), .nan_o(nb),
        .exp_o(eb), .sig_o(mb)
    );

    assign res_sign = sa ^ sb;
    assign exp_pre  = ea - eb + XW'(BIAS);   // R6

    // ordered screening: NaN, zero dividend, zero divisor, infinities, range
    always_comb begin
        if (na | nb | (za & zb) | (ia & ib)) begin
            kind = K_NAN;                               // R2
        end else if (za) begin
            kind = K_ZERO;                              // R3
        end else if (zb) begin
            kind = ia ? K_INF : K_DBZ;                  // R4
        end else if (ia) begin
            kind = K_INF;                               // R5
        end else if (ib) begin
            kind = K_ZERO;                              // R5
        end else if (int'(exp_pre) >= EOVF) begin
            kind = K_OVF;                               // R7
        end else if (int'(exp_pre) <= 0) begin
            kind = K_UNF;                               // R7
        end else begin
            kind = K_DIV;
        end
    end

    always_comb begin
        unique case (kind)
            K_NAN:               spec_res = QNAN;
            K_ZERO, K_UNF:       spec_res = {res_sign, {(W - 1){1'b0}}};
            K_INF, K_DBZ, K_OVF: spec_res = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            default:             spec_res = '0;
        endcase
    end

    // ---------------- significand divider and rounding ----------------
    fpdiv_restore #(.SW(SW), .QW(QW)) i_div (
        .clk(clk), .rst(rst), .load_i(load), .step_i(step),
        .divd_i(ma), .dvsr_i(mb), .quot_o(raw_q), .rem_nz_o(rem_nz)
    );

    fpdiv_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_rnd (
        .quot_i(raw_q), .rem_nz_i(rem_nz), .exp_i(exp_q), .sign_i(res_sign),
        .res_o(rnd_res), .ovf_o(rnd_ovf), .unf_o(rnd_unf)
    );

    // ---------------- controller ----------------
    assign last_bit = (cnt_q == CW'(QW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_PREP;
            S_PREP:  state_d = (kind == K_DIV) ? S_DIV : S_FIN;
            S_DIV:   if (last_bit) state_d = S_ROUND;
            S_ROUND: state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy_o = 1'b0;
        done_o = 1'b0;
        load   = 1'b0;
        step   = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_PREP:  begin busy_o = 1'b1; load = (kind == K_DIV); end
            S_DIV:   begin busy_o = 1'b1; step = 1'b1; end
            S_ROUND: busy_o = 1'b1;
            S_FIN:   begin busy_o = 1'b1; done_o = 1'b1; end
            default: ;
        endcase
    end

    // operand capture, iteration count and exponent hold
    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
            cnt_q <= '0;
            exp_q <= '0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                opa_q <= dividend_i;
                opb_q <= divisor_i;
            end
            if (state_q == S_PREP) begin
                cnt_q <= '0;
                exp_q <= exp_pre;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // result registers: written only on the way to FIN
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            dbz_q <= 1'b0;
        end else if (state_q == S_PREP && kind != K_DIV) begin
            res_q <= spec_res;
            ovf_q <= (kind == K_OVF);
            unf_q <= (kind == K_UNF);
            dbz_q <= (kind == K_DBZ);
        end else if (state_q == S_ROUND) begin
            res_q <= rnd_res;
            ovf_q <= rnd_ovf;
            unf_q <= rnd_unf;
            dbz_q <= 1'b0;
        end
    end

    assign quot_o = res_q;
    assign ovf_o  = ovf_q;
    assign unf_o  = unf_q;
    assign dbz_o  = dbz_q;

endmodule

// File: rtl/fpdiv_seq_chk.sv
module fpdiv_seq_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [EXP_W+FRAC_W:0] quot_o,
    input logic                  ovf_o,
    input logic                  unf_o,
    input logic                  dbz_o
);
    localparam logic [EXP_W+FRAC_W-1:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                          // R12

    AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);                                           // R8

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);                             // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && $past(!busy_o)) |-> ($stable(quot_o) && $stable({ovf_o, unf_o, dbz_o}))); // R12

    AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (rst)
        (done_o && ovf_o) |-> (quot_o[EXP_W+FRAC_W-1:0] == INF_MAG));  // R7

    AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_o && unf_o) |-> (quot_o[EXP_W+FRAC_W-1:0] == '0));       // R11

    AST_DBZ_IS_INF: assert property (@(posedge clk) disable iff (rst)
        (done_o && dbz_o) |-> (quot_o[EXP_W+FRAC_W-1:0] == INF_MAG));  // R4

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones({ovf_o, unf_o, dbz_o}) <= 1));           // R11

endmodule

bind fpdiv_seq fpdiv_seq_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .quot_o(quot_o), .ovf_o(ovf_o), .unf_o(unf_o), .dbz_o(dbz_o)
);

// File: tb/test_fpdiv_seq.sv
module test_fpdiv_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        logic        unf;
        logic        dbz;
        int          lat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o, done_o, ovf_o, unf_o, dbz_o;
    logic [31:0] quot_o;

    int   checks = 0;
    int   fails  = 0;
    int   lat    = 0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpdiv_seq i_fpdiv_seq (
        .clk(clk), .rst(rst), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
        .ovf_o(ovf_o), .unf_o(unf_o), .dbz_o(dbz_o)
    );

    function automatic void check(input string req, input string what,
                                  input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endfunction

    // subnormals normalized: leading one at bit 23, exponent 1 - shift (R6)
    function automatic void split(input logic [31:0] x, output int e, output longint unsigned m);
        if (x[30:23] == 8'd0) begin
            m = longint'(x[22:0]);
            e = 1;
            while (m[23] == 1'b0) begin
                m = m << 1;
                e = e - 1;
            end
        end else begin
            m = longint'({1'b1, x[22:0]});
            e = int'(x[30:23]);
        end
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_t r;
        logic sg, az, bz, ai, bi, an, bn, g, s;
        int ea, eb, eq, e;
        longint unsigned ma, mb, q, rm, sig;
        r.tag = tag; r.ovf = 0; r.unf = 0; r.dbz = 0; r.lat = 2;
        sg = a[31] ^ b[31];
        az = (a[30:0] == 0);
        bz = (b[30:0] == 0);
        ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        if (an || bn || (az && bz) || (ai && bi)) r.res = 32'h7FC00000;
        else if (az) r.res = {sg, 31'd0};
        else if (bz) begin r.res = {sg, 8'hFF, 23'd0}; r.dbz = !ai; end
        else if (ai) r.res = {sg, 8'hFF, 23'd0};
        else if (bi) r.res = {sg, 31'd0};
        else begin
            split(a, ea, ma);
            split(b, eb, mb);
            eq = ea - eb + 127;
            if (eq >= 256) begin r.res = {sg, 8'hFF, 23'd0}; r.ovf = 1; end
            else if (eq <= 0) begin r.res = {sg, 31'd0}; r.unf = 1; end
            else begin
                r.lat = 29;
                q  = (ma << 25) / mb;
                rm = (ma << 25) % mb;
                if (q >= (64'd1 << 25)) begin
                    sig = q >> 2; g = q[1]; s = q[0] | (rm != 0); e = eq;
                end else begin
                    sig = q >> 1; g = q[0]; s = (rm != 0); e = eq - 1;
                end
                if (g && (s || sig[0])) sig = sig + 1;
                if (sig == (64'd1 << 24)) begin sig = sig >> 1; e = e + 1; end
                if (e >= 255) begin r.res = {sg, 8'hFF, 23'd0}; r.ovf = 1; end
                else if (e <= 0) begin r.res = {sg, 31'd0}; r.unf = 1; end
                else r.res = {sg, e[7:0], sig[22:0]};
            end
        end
        return r;
    endfunction

    // driver: push the expectation, pulse start, wait for idle
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input string tag);
        sb_q.push_back(model(a, b, tag));
        last_exp = model(a, b, tag);
        @(negedge clk);
        dividend_i = a; divisor_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
    endtask

    // monitor: latency count and comparison against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o) lat++;
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    check("R8", "unexpected done", 1, 0);
                end else begin
                    exp_t x;
                    x = sb_q.pop_front();
                    check(x.tag, "result", longint'(quot_o), longint'(x.res));
                    check(x.tag, "flags ovf/unf/dbz", longint'({ovf_o, unf_o, dbz_o}),
                          longint'({x.ovf, x.unf, x.dbz}));
                    check(x.lat == 2 ? x.tag : "R8", "latency", longint'(lat), longint'(x.lat));
                end
                lat = 0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy/done", longint'({busy_o, done_o}), 0);
        check("R1", "result", longint'(quot_o), 0);
        check("R1", "flags", longint'({ovf_o, unf_o, dbz_o}), 0);

        // R2 NaN cases
        issue(32'h7FC00001, 32'h3F800000, "R2");
        issue(32'h40000000, 32'hFF800123, "R2");
        issue(32'h00000000, 32'h80000000, "R2");
        issue(32'h7F800000, 32'hFF800000, "R2");
        // R3 zero dividend
        issue(32'h00000000, 32'h40A00000, "R3");
        issue(32'h80000000, 32'h40400000, "R3");
        issue(32'h00000000, 32'hFF800000, "R3");
        // R4 zero divisor
        issue(32'h40A00000, 32'h00000000, "R4");
        issue(32'hC0A00000, 32'h00000000, "R4");
        issue(32'h7F800000, 32'h80000000, "R4");
        issue(32'h00000003, 32'h00000000, "R4");
        // R5 infinities
        issue(32'hFF800000, 32'h40400000, "R5");
        issue(32'h40400000, 32'hFF800000, "R5");
        // R6 exponent and subnormal operands
        issue(32'h40C00000, 32'h40000000, "R6");
        issue(32'hC0E00000, 32'h40000000, "R6");
        issue(32'h00000001, 32'h00800000, "R6");
        issue(32'h3F800000, 32'h00200000, "R6");
        // R7 early range rejection
        issue(32'h3F800000, 32'h00000001, "R7");
        issue(32'h7F000000, 32'h00800000, "R7");
        issue(32'h00800000, 32'h7F000000, "R7");
        issue(32'h80800000, 32'h7F000000, "R7");
        // R9 ratio below one
        issue(32'h40000000, 32'h40400000, "R9");
        issue(32'h3F800000, 32'h3FC00000, "R9");
        // R10 rounding up and down
        issue(32'h3F800000, 32'h40400000, "R10");
        issue(32'h3F800000, 32'h41300000, "R10");
        issue(32'h3F800000, 32'h40E00000, "R10");
        issue(32'h3FFFFFFF, 32'h3F800001, "R10");
        // R11 late overflow and underflow
        issue(32'h7F7FFFFF, 32'h3F000000, "R11");
        issue(32'h00800000, 32'h3FC00000, "R11");
        issue(32'h80800000, 32'h3FC00000, "R11");

        // R8: start during a division is ignored
        sb_q.push_back(model(32'h40400000, 32'h3F800000, "R8"));
        last_exp = model(32'h40400000, 32'h3F800000, "R8");
        @(negedge clk);
        dividend_i = 32'h40400000; divisor_i = 32'h3F800000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        dividend_i = 32'h00000000; divisor_i = 32'h00000000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R8", "no second operation", longint'(busy_o), 0);

        // R12 result held while idle
        check("R12", "held result", longint'(quot_o), longint'(last_exp.res));
        check("R12", "held flags", longint'({ovf_o, unf_o, dbz_o}),
              longint'({last_exp.ovf, last_exp.unf, last_exp.dbz}));
        check("R8", "scoreboard drained", longint'(sb_q.size()), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule